// File: doc/BRIEF.md
# Software-Interrupt Pending-Source Register File

This block keeps the pending state of the software interrupts that one CPU interface can receive. For each software interrupt it holds a source mask with one bit per possible sender CPU and a pending flag. The flag is raised when any source asserts a request. It is dropped only when a clear removes the last remaining source.

Software reaches the masks through two byte-addressed windows on a simple register bus. A write to the set window adds sender bits. A write to the clear window removes them. A read of either window returns the current source bytes. Independently, an interrupt dispatcher can post a single request, naming an interrupt and a sender, in any cycle. The flags and masks are presented as flat output vectors for the downstream priority and acknowledge logic.

Top module: `sgi_pend_regs`

## Requirements
- R1: While `rst_n` is low, every source mask and every pending flag is cleared to zero.
- R2: Window select is `bus_addr[5:4]`: 2'b10 selects the set window and 2'b01 selects the clear window. A write with code 2'b00 or 2'b11 changes nothing. A read with one of those codes returns zero.
- R3: A narrow access (`bus_wide`=0) uses byte lane 0 (`bus_wdata[7:0]`, `bus_rdata[7:0]`) for interrupt `bus_addr[3:0]`, and the other read lanes return zero. A wide access (`bus_wide`=1) ignores `bus_addr[1:0]` and maps lane k (bits 8k+7..8k) to interrupt {`bus_addr[3:2]`,2'b00}+k.
- R4: A read (`bus_sel`=1, `bus_write`=0) returns the selected source bytes on `bus_rdata` one cycle later. The returned value is the state before any update made in the same cycle as the read. `bus_rdata` is zero in cycles that follow no read.
- R5: A set-window byte that is not zero is ORed into that interrupt's source mask, and the interrupt's pending flag is set.
- R6: A set-window byte of zero leaves that interrupt's source mask and pending flag unchanged.
- R7: A clear-window byte removes its one bits from the source mask. The pending flag drops only if the mask becomes zero; otherwise the flag stays set.
- R8: When `disp_valid` is high, source bit `disp_src` of interrupt `disp_sgi` is set and that interrupt's pending flag is set, one cycle later.
- R9: If a dispatcher request and a clear write hit the same bit in the same cycle, the bit ends up set. Other bits of the same write still take effect.
- R10: At every cycle, each pending flag equals the OR of its interrupt's source mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Window code [5:4] and byte offset [3:0] |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_wdata | input | 32 | Write data, one source byte per lane |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| disp_valid | input | 1 | Dispatcher request strobe |
| disp_sgi | input | 4 | Interrupt number of the dispatcher request |
| disp_src | input | 3 | Sender CPU of the dispatcher request |
| sgi_pending | output | 16 | Pending flag per interrupt |
| sgi_sources | output | 128 | Source masks, interrupt n at bits 8n+7..8n |

## Verification
Every result of this block appears one clock after its cause. Mask and flag updates are visible after the rising edge that captures the write or the dispatcher pulse. Read data is registered on that same edge. The bench drives each access on a falling edge and holds it through the next rising edge. It then compares `bus_rdata`, `sgi_pending` and `sgi_sources` at the following falling edge, against a model that has applied exactly that access. The expected read data is taken from the model before the update, so a read that coincides with a dispatcher pulse is checked against the old state.

// File: rtl/sgi_pend_pkg.sv
package sgi_pend_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    WIN_NONE = 2'b00,
    WIN_CLR  = 2'b01,
    WIN_SET  = 2'b10,
    WIN_RSVD = 2'b11
  } win_e;

  // Interrupt number served by one byte lane of an access.
  function automatic int lane_index(input int offs, input logic wide,
                                    input int lane, input int lanes);
    if (wide) return (offs - (offs % lanes)) + lane;
    return offs;
  endfunction

  // Only lane 0 carries data on a byte access.
  function automatic logic lane_live(input logic wide, input int lane);
    return wide || (lane == 0);
  endfunction

  // Next source mask: clears first, then sets (sets win per bit).
  function automatic logic [BYTE_W-1:0] next_mask(
      input logic [BYTE_W-1:0] cur, input logic [BYTE_W-1:0] clr,
      input logic [BYTE_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/sgi_bus_decode.sv
module sgi_bus_decode
  import sgi_pend_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SGI),
  localparam int unsigned ADDR_W = IDX_W + 2,
  localparam int unsigned LANES  = DATA_W / BYTE_W
) (
  input  logic                     bus_sel,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wide,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [NUM_SGI*SRC_W-1:0] set_mask,
  output logic [NUM_SGI*SRC_W-1:0] clr_mask
);

  win_e win;
  logic wr_set, wr_clr;
  int   offs;

  assign win    = win_e'(bus_addr[ADDR_W-1 -: 2]);
  assign wr_set = bus_sel && bus_write && (win == WIN_SET);
  assign wr_clr = bus_sel && bus_write && (win == WIN_CLR);
  assign offs   = int'(bus_addr[IDX_W-1:0]);

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      int idx;
      idx = lane_index(offs, bus_wide, l, int'(LANES));
      if (lane_live(bus_wide, l) && idx < int'(NUM_SGI)) begin
        if (wr_set) set_mask[idx*SRC_W +: SRC_W] = bus_wdata[l*BYTE_W +: SRC_W];
        if (wr_clr) clr_mask[idx*SRC_W +: SRC_W] = bus_wdata[l*BYTE_W +: SRC_W];
      end
    end
  end

endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell
  import sgi_pend_pkg::*;
#(
  parameter int unsigned SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_bits,
  input  logic [SRC_W-1:0] clr_bits,
  input  logic [SRC_W-1:0] disp_bits,
  output logic [SRC_W-1:0] src_q,
  output logic             pend_q
);

  logic [BYTE_W-1:0] nxt_full;
  logic [SRC_W-1:0]  src_d;
  logic              pend_d;
  logic              any_set;

  assign any_set  = |(set_bits | disp_bits);
  assign nxt_full = next_mask(BYTE_W'(src_q), BYTE_W'(clr_bits),
                              BYTE_W'(set_bits | disp_bits));
  assign src_d    = nxt_full[SRC_W-1:0];

  always_comb begin
    pend_d = pend_q;
    if (any_set)                      pend_d = 1'b1;
    else if (|clr_bits && src_d == '0) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/sgi_read_port.sv
module sgi_read_port
  import sgi_pend_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SGI),
  localparam int unsigned ADDR_W = IDX_W + 2,
  localparam int unsigned LANES  = DATA_W / BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wide,
  input  logic [NUM_SGI*SRC_W-1:0] src_flat,
  output logic [DATA_W-1:0]        bus_rdata
);

  win_e              win;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_val;

  assign win    = win_e'(bus_addr[ADDR_W-1 -: 2]);
  assign rd_hit = bus_sel && !bus_write && (win == WIN_SET || win == WIN_CLR);

  always_comb begin
    rd_val = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      int idx;
      idx = lane_index(int'(bus_addr[IDX_W-1:0]), bus_wide, l, int'(LANES));
      if (rd_hit && lane_live(bus_wide, l) && idx < int'(NUM_SGI))
        rd_val[l*BYTE_W +: SRC_W] = src_flat[idx*SRC_W +: SRC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_val;
  end

endmodule

// File: rtl/sgi_pend_regs.sv
module sgi_pend_regs
  import sgi_pend_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SGI),
  localparam int unsigned ADDR_W = IDX_W + 2,
  localparam int unsigned SID_W  = (SRC_W > 1) ? $clog2(SRC_W) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wide,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     disp_valid,
  input  logic [IDX_W-1:0]         disp_sgi,
  input  logic [SID_W-1:0]         disp_src,
  output logic [NUM_SGI-1:0]       sgi_pending,
  output logic [NUM_SGI*SRC_W-1:0] sgi_sources
);

  // Internal events, named for the checker.
  logic [NUM_SGI*SRC_W-1:0] set_mask_w;
  logic [NUM_SGI*SRC_W-1:0] clr_mask_w;
  logic [NUM_SGI*SRC_W-1:0] disp_mask_w;

  sgi_bus_decode #(.NUM_SGI(NUM_SGI), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wide (bus_wide),
    .bus_wdata(bus_wdata),
    .set_mask (set_mask_w),
    .clr_mask (clr_mask_w)
  );

  for (genvar g = 0; g < int'(NUM_SGI); g++) begin : g_cell
    assign disp_mask_w[g*SRC_W +: SRC_W] =
      (disp_valid && disp_sgi == IDX_W'(g)) ? (SRC_W'(1) << disp_src) : '0;

    sgi_src_cell #(.SRC_W(SRC_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_mask_w[g*SRC_W +: SRC_W]),
      .clr_bits (clr_mask_w[g*SRC_W +: SRC_W]),
      .disp_bits(disp_mask_w[g*SRC_W +: SRC_W]),
      .src_q    (sgi_sources[g*SRC_W +: SRC_W]),
      .pend_q   (sgi_pending[g])
    );
  end

  sgi_read_port #(.NUM_SGI(NUM_SGI), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wide (bus_wide),
    .src_flat (sgi_sources),
    .bus_rdata(bus_rdata)
  );

endmodule

// File: rtl/sgi_pend_regs_chk.sv
module sgi_pend_regs_chk #(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned SRC_W   = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SGI),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic                     bus_write,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_wide,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_SGI-1:0]       sgi_pending,
  input logic [NUM_SGI*SRC_W-1:0] sgi_sources,
  input logic [NUM_SGI*SRC_W-1:0] set_mask_w,
  input logic [NUM_SGI*SRC_W-1:0] clr_mask_w,
  input logic [NUM_SGI*SRC_W-1:0] disp_mask_w
);

  logic             bad_win_rd;
  logic             narrow_rd;
  logic [SRC_W-1:0] narrow_src;

  assign bad_win_rd = bus_sel && !bus_write &&
                      (bus_addr[ADDR_W-1 -: 2] == 2'b00 || bus_addr[ADDR_W-1 -: 2] == 2'b11);
  assign narrow_rd  = bus_sel && !bus_write && !bus_wide &&
                      (bus_addr[ADDR_W-1 -: 2] == 2'b01 || bus_addr[ADDR_W-1 -: 2] == 2'b10);
  assign narrow_src = sgi_sources[bus_addr[IDX_W-1:0]*SRC_W +: SRC_W];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (sgi_pending == '0 && sgi_sources == '0));

  p_bad_window_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_win_rd |=> bus_rdata == '0);

  p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_rd |=> bus_rdata[SRC_W-1:0] == $past(narrow_src));

  for (genvar g = 0; g < int'(NUM_SGI); g++) begin : g_sgi
    p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask_w[g*SRC_W +: SRC_W] != '0 |=>
        sgi_pending[g] &&
        ((sgi_sources[g*SRC_W +: SRC_W] & $past(set_mask_w[g*SRC_W +: SRC_W]))
          == $past(set_mask_w[g*SRC_W +: SRC_W])));

    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask_w[g*SRC_W +: SRC_W] == '0 && clr_mask_w[g*SRC_W +: SRC_W] == '0 &&
       disp_mask_w[g*SRC_W +: SRC_W] == '0) |=>
        $stable(sgi_sources[g*SRC_W +: SRC_W]) && $stable(sgi_pending[g]));

    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask_w[g*SRC_W +: SRC_W] != '0 && disp_mask_w[g*SRC_W +: SRC_W] == '0) |=>
        (sgi_sources[g*SRC_W +: SRC_W] & $past(clr_mask_w[g*SRC_W +: SRC_W])) == '0);

    p_disp_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      disp_mask_w[g*SRC_W +: SRC_W] != '0 |=>
        sgi_pending[g] &&
        ((sgi_sources[g*SRC_W +: SRC_W] & $past(disp_mask_w[g*SRC_W +: SRC_W]))
          == $past(disp_mask_w[g*SRC_W +: SRC_W])));

    p_pend_tracks_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sgi_pending[g] == (sgi_sources[g*SRC_W +: SRC_W] != '0));
  end

endmodule

bind sgi_pend_regs sgi_pend_regs_chk #(
  .NUM_SGI(NUM_SGI), .SRC_W(SRC_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wide   (bus_wide),
  .bus_rdata  (bus_rdata),
  .sgi_pending(sgi_pending),
  .sgi_sources(sgi_sources),
  .set_mask_w (set_mask_w),
  .clr_mask_w (clr_mask_w),
  .disp_mask_w(disp_mask_w)
);

// File: tb/sgi_pend_regs_test.sv
`timescale 1ns/1ps
module sgi_pend_regs_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         disp_valid = 1'b0;
  logic [3:0]   disp_sgi = '0;
  logic [2:0]   disp_src = '0;
  logic [15:0]  sgi_pending;
  logic [127:0] sgi_sources;

  int total = 0;
  int bad   = 0;

  logic [7:0] m_src [16];
  logic       m_pend [16];

  always #10 clk = ~clk;

  sgi_pend_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .disp_valid(disp_valid), .disp_sgi(disp_sgi),
    .disp_src(disp_src), .sgi_pending(sgi_pending), .sgi_sources(sgi_sources)
  );

  // Interrupt served by lane l (R3).
  function automatic int tgt(input logic [5:0] a, input logic w, input int l);
    return w ? int'({a[3:2], 2'b00}) + l : int'(a[3:0]);
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] a, input logic w);
    logic [31:0] r = '0;
    if (a[5:4] == 2'b01 || a[5:4] == 2'b10) begin
      if (w) for (int l = 0; l < 4; l++) r[l*8 +: 8] = m_src[tgt(a, w, l)];
      else   r[7:0] = m_src[a[3:0]];
    end
    return r;
  endfunction

  function automatic logic [127:0] pack_src();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_src[i];
    return v;
  endfunction

  function automatic logic [15:0] pack_pend();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = m_pend[i];
    return v;
  endfunction

  task automatic model_apply(input logic sel, input logic wr, input logic [5:0] a,
                             input logic w, input logic [31:0] d, input logic dv,
                             input logic [3:0] ds, input logic [2:0] dc);
    logic [7:0] s [16];
    logic [7:0] c [16];
    for (int i = 0; i < 16; i++) begin s[i] = '0; c[i] = '0; end
    if (sel && wr) begin
      for (int l = 0; l < (w ? 4 : 1); l++) begin
        if (a[5:4] == 2'b10) s[tgt(a, w, l)] = d[l*8 +: 8];
        if (a[5:4] == 2'b01) c[tgt(a, w, l)] = d[l*8 +: 8];
      end
    end
    if (dv) s[ds] = s[ds] | (8'd1 << dc);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] after;
      after = m_src[i];
      for (int b = 0; b < 8; b++) begin
        if (s[i][b])      after[b] = 1'b1;
        else if (c[i][b]) after[b] = 1'b0;
      end
      if (s[i] != 0)                    m_pend[i] = 1'b1;
      else if (c[i] != 0 && after == 0) m_pend[i] = 1'b0;
      m_src[i] = after;
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; checks at the next falling edge.
  task automatic step(input string tag, input logic sel, input logic wr,
                      input logic [5:0] a, input logic w, input logic [31:0] d,
                      input logic dv, input logic [3:0] ds, input logic [2:0] dc);
    logic [31:0] exp_rd;
    bus_sel = sel; bus_write = wr; bus_addr = a; bus_wide = w; bus_wdata = d;
    disp_valid = dv; disp_sgi = ds; disp_src = dc;
    exp_rd = (sel && !wr) ? model_read(a, w) : 32'h0;
    model_apply(sel, wr, a, w, d, dv, ds, dc);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; disp_valid = 1'b0;
    check(tag, "rdata", 128'(bus_rdata), 128'(exp_rd));
    check(tag, "sources", sgi_sources, pack_src());
    check(tag, "pending", 128'(sgi_pending), 128'(pack_pend()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) begin m_src[i] = '0; m_pend[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "sources", sgi_sources, '0);
    check("R1", "pending", 128'(sgi_pending), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: narrow set of sgi 5
    step("R5", 1, 1, 6'h25, 0, 32'h03, 0, 0, 0);
    // R4: read both windows, narrow
    step("R4", 1, 0, 6'h25, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 6'h15, 0, 0, 0, 0, 0);
    // R7: partial clear keeps pending, final clear drops it
    step("R7", 1, 1, 6'h15, 0, 32'h01, 0, 0, 0);
    step("R7", 1, 1, 6'h15, 0, 32'h02, 0, 0, 0);
    // R6: zero byte on set leaves state
    step("R6", 1, 1, 6'h25, 0, 32'h00, 0, 0, 0);
    step("R6", 1, 1, 6'h2a, 1, 32'h00_44_00_11, 0, 0, 0);
    // R3: wide set, low address bits ignored, lanes to sgi 8..11
    step("R3", 1, 1, 6'h2b, 1, 32'h80_00_40_20, 0, 0, 0);
    step("R3", 1, 0, 6'h19, 1, 0, 0, 0, 0);
    // R2: reserved window codes ignored and read zero
    step("R2", 1, 1, 6'h38, 1, 32'hff_ff_ff_ff, 0, 0, 0);
    step("R2", 1, 1, 6'h08, 0, 32'hff, 0, 0, 0);
    step("R2", 1, 0, 6'h38, 1, 0, 0, 0, 0);
    // R8: dispatcher pulse
    step("R8", 0, 0, 0, 0, 0, 1, 4'd15, 3'd7);
    // R9: dispatcher wins against clear of the same bit
    step("R9", 1, 1, 6'h1c, 1, 32'hff_00_00_00, 1, 4'd15, 3'd7);
    step("R9", 1, 1, 6'h1c, 1, 32'hff_00_00_00, 1, 4'd15, 3'd2);
    // R4: read in the same cycle as a dispatcher pulse sees the old value
    step("R4", 1, 0, 6'h23, 0, 0, 1, 4'd3, 3'd4);
    step("R4", 1, 0, 6'h23, 0, 0, 0, 0, 0);

    // R10 and mixed: constrained random
    for (int n = 0; n < 400; n++) begin
      logic [5:0]  a;
      logic [31:0] d;
      logic        sel, wr, w;
      sel = ($urandom % 4) != 0;
      wr  = ($urandom % 3) != 0;
      w   = $urandom % 2;
      a   = 6'($urandom);
      if (($urandom % 8) != 0) a[5:4] = (($urandom % 2) != 0) ? 2'b10 : 2'b01;
      d = $urandom;
      for (int l = 0; l < 4; l++) if (($urandom % 4) == 0) d[l*8 +: 8] = 8'h00;
      step("R10", sel, wr, a, w, d, ($urandom % 3) == 0, 4'($urandom), 3'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule